// File: doc/BRIEF.md
# Exception Priority Sequencer

This block sits next to a processor core and decides which pending exception is processed next, and when. Each exception source drives one request line. A request is held until it is granted or wiped out by a reset exception. The core reports three events with one-cycle pulses: an instruction starting, an instruction finishing, and exception processing finishing. From these pulses the block tracks which phase the core is in. Each exception group may only start in certain phases. Faults may cut in at any time, software traps only while an instruction runs, and opcode violations only as an instruction begins. Trace, hardware breakpoint and interrupt wait for a clean boundary between instructions.

At each legal decision point the highest-priority eligible request is granted. The grant is a one-cycle pulse that carries a 3-bit group code and a flag telling the core whether the old context must be saved. Each context-saving grant stacks one more context, and each handler return pops one. The block therefore keeps a count of stacked contexts. Since contexts are stacked in processing order, handlers run in the reverse order and the count unwinds back to zero.

Top module: `exc_prio_seq`

## Requirements
- R1: A request bit seen on `exc_req` stays pending until it is granted or flushed. A request that is not yet eligible is granted later, once its phase condition holds, without being raised again.
- R2: Bit 0 of `exc_req` (reset, code 0) is granted in the next cycle in every phase. It clears all other pending requests, including those arriving in the same cycle, and it clears `ctx_depth` to 0.
- R3: `save_ctx` is 0 on a code 0 grant and 1 on grants of codes 1 to 7.
- R4: Codes 1 (address fault) and 2 (bus fault) are eligible in every phase, including while exception processing is under way.
- R5: Code 3 (software trap) is eligible only while an instruction executes, meaning the phase after `insn_start` and before `insn_done`.
- R6: Code 4 (illegal or privileged opcode) is eligible only in a cycle where `insn_start` pulses while the core is between instructions.
- R7: Codes 5 (trace), 6 (hardware breakpoint) and 7 (interrupt) are eligible only between instructions. That is the phase after block reset, after `insn_done`, or after `exc_done`.
- R8: Among eligible requests the lowest code wins. At most one grant is issued per cycle, as a one-cycle `grant_valid` pulse in the cycle after the decision.
- R9: `ctx_depth` rises by 1 on each grant of codes 1 to 7 and holds at its maximum, falls by 1 on `handler_return` and holds at 0, and stays unchanged when both happen in the same cycle.
- R10: Any grant moves the phase to exception processing. `insn_start` moves from between-instructions to executing, `insn_done` moves from executing back to between-instructions, and `exc_done` ends exception processing. A grant overrides these pulses.
- R11: Block reset (`rst_n` low) leaves no grant, nothing pending, depth 0, and the phase between instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| exc_req | input | 8 | Exception requests, bit index equals group code |
| insn_start | input | 1 | Pulse: an instruction begins |
| insn_done | input | 1 | Pulse: the current instruction completed |
| exc_done | input | 1 | Pulse: exception processing completed |
| handler_return | input | 1 | Pulse: a handler returned, one context popped |
| grant_valid | output | 1 | One-cycle grant pulse |
| grant_code | output | 3 | Group code of the granted exception |
| save_ctx | output | 1 | Granted exception must save the old context |
| ctx_depth | output | DEPTH_W | Number of stacked contexts |

## Verification
The hardest case to reach is a request set that arrives in a phase where only part of it may start. The higher-priority members that are not yet eligible must wait, while a lower one goes first. To reach it, the stimulus first steers the core into each phase through the event pulses: idle, executing, exception processing after a setup fault, and idle with an instruction start in the same cycle. In each phase it then applies all 255 non-empty request sets and computes the expected winner from the phase rules. A second hard case is the chain of trap, then trace, then interrupt, followed by a bus fault during exception processing. It is driven as a directed sequence, and the context count is then unwound to zero with handler returns.

// File: rtl/eps_pkg.sv
package eps_pkg;
    localparam int unsigned NGRP   = 8;
    localparam int unsigned CODE_W = 3;

    localparam int unsigned C_RESET = 0;
    localparam int unsigned C_ADDR  = 1;
    localparam int unsigned C_BUS   = 2;
    localparam int unsigned C_TRAP  = 3;
    localparam int unsigned C_ILL   = 4;
    localparam int unsigned C_TRACE = 5;
    localparam int unsigned C_HWBK  = 6;
    localparam int unsigned C_IRQ   = 7;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_EXEC = 2'd1,
        PH_EXC  = 2'd2
    } phase_e;
endpackage

// File: rtl/eps_pending.sv
module eps_pending
    import eps_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NGRP-1:0] req,
    input  logic            flush,
    input  logic [NGRP-1:0] grant_oh,
    output logic [NGRP-1:0] pend_eff
);
    typedef struct packed {
        logic [NGRP-1:0] pend;
    } pend_state_t;

    pend_state_t s_d, s_q;

    assign pend_eff = s_q.pend | req;

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d.pend = '0;
        end else begin
            s_d.pend = pend_eff & ~grant_oh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R2: a reset grant leaves nothing pending
    p_flush_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (s_q.pend == '0));

    // R1: a pending bit not granted and not flushed survives
    p_hold_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> ((($past(s_q.pend) & ~$past(grant_oh)) & ~s_q.pend) == '0));
endmodule

// File: rtl/eps_picker.sv
module eps_picker
    import eps_pkg::*;
(
    input  logic [NGRP-1:0]   elig,
    output logic              any,
    output logic [CODE_W-1:0] code,
    output logic [NGRP-1:0]   onehot
);
    always_comb begin
        any    = |elig;
        code   = '0;
        onehot = '0;
        for (int i = NGRP - 1; i >= 0; i--) begin
            if (elig[i]) begin
                code      = CODE_W'(i);
                onehot    = '0;
                onehot[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/eps_depth.sv
module eps_depth #(
    parameter int unsigned DEPTH_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inc,
    input  logic               dec,
    input  logic               clr,
    output logic [DEPTH_W-1:0] depth
);
    localparam logic [DEPTH_W-1:0] DEPTH_MAX = {DEPTH_W{1'b1}};

    typedef struct packed {
        logic [DEPTH_W-1:0] cnt;
    } depth_state_t;

    depth_state_t s_d, s_q;

    assign depth = s_q.cnt;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.cnt = '0;
        end else if (inc && !dec) begin
            if (s_q.cnt != DEPTH_MAX) s_d.cnt = s_q.cnt + 1'b1;
        end else if (dec && !inc) begin
            if (s_q.cnt != '0) s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R9: the count moves by at most one step per cycle
    p_depth_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (s_q.cnt == $past(s_q.cnt) ||
                  s_q.cnt == $past(s_q.cnt) + 1'b1 ||
                  s_q.cnt == $past(s_q.cnt) - 1'b1));

    // R2: a reset grant empties the stack count
    p_depth_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (s_q.cnt == '0));
endmodule

// File: rtl/exc_prio_seq.sv
module exc_prio_seq
    import eps_pkg::*;
#(
    parameter int unsigned DEPTH_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         exc_req,
    input  logic               insn_start,
    input  logic               insn_done,
    input  logic               exc_done,
    input  logic               handler_return,
    output logic               grant_valid,
    output logic [2:0]         grant_code,
    output logic               save_ctx,
    output logic [DEPTH_W-1:0] ctx_depth
);
    typedef struct packed {
        phase_e            phase;
        logic              gv;
        logic [CODE_W-1:0] code;
        logic              save;
    } seq_state_t;

    seq_state_t s_d, s_q;

    logic [NGRP-1:0]   pend_eff;
    logic [NGRP-1:0]   elig;
    logic              pick_any;
    logic [CODE_W-1:0] pick_code;
    logic [NGRP-1:0]   pick_oh;
    logic              flush;
    logic              is_idle;
    logic              is_exec;

    assign is_idle = (s_q.phase == PH_IDLE);
    assign is_exec = (s_q.phase == PH_EXEC);
    assign flush   = pick_any && (pick_code == CODE_W'(C_RESET));

    eps_pending i_pending (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (exc_req),
        .flush    (flush),
        .grant_oh (pick_oh),
        .pend_eff (pend_eff)
    );

    // Phase gating of each group
    always_comb begin
        elig          = '0;
        elig[C_RESET] = pend_eff[C_RESET];
        elig[C_ADDR]  = pend_eff[C_ADDR];
        elig[C_BUS]   = pend_eff[C_BUS];
        elig[C_TRAP]  = pend_eff[C_TRAP] && is_exec;
        elig[C_ILL]   = pend_eff[C_ILL] && is_idle && insn_start;
        elig[C_TRACE] = pend_eff[C_TRACE] && is_idle;
        elig[C_HWBK]  = pend_eff[C_HWBK] && is_idle;
        elig[C_IRQ]   = pend_eff[C_IRQ] && is_idle;
    end

    eps_picker i_picker (
        .elig   (elig),
        .any    (pick_any),
        .code   (pick_code),
        .onehot (pick_oh)
    );

    eps_depth #(.DEPTH_W(DEPTH_W)) i_depth (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (pick_any && !flush),
        .dec   (handler_return),
        .clr   (flush),
        .depth (ctx_depth)
    );

    always_comb begin
        s_d      = s_q;
        s_d.gv   = pick_any;
        s_d.code = pick_code;
        s_d.save = pick_any && !flush;
        if (pick_any) begin
            s_d.phase = PH_EXC;
        end else begin
            unique case (s_q.phase)
                PH_IDLE: if (insn_start) s_d.phase = PH_EXEC;
                PH_EXEC: if (insn_done)  s_d.phase = PH_IDLE;
                PH_EXC:  if (exc_done)   s_d.phase = PH_IDLE;
                default: s_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, gv: 1'b0, code: '0, save: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign grant_valid = s_q.gv;
    assign grant_code  = s_q.code;
    assign save_ctx    = s_q.save;

    // R3: context saving follows the granted code
    p_save_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.gv |-> (s_q.save == (s_q.code != '0)));

    // R5: traps start only inside an executing instruction
    p_trap_in_exec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.gv && s_q.code == CODE_W'(C_TRAP)) |-> ($past(s_q.phase) == PH_EXEC));

    // R6: opcode violations start only with an instruction start
    p_ill_at_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.gv && s_q.code == CODE_W'(C_ILL)) |->
            ($past(insn_start) && $past(s_q.phase) == PH_IDLE));

    // R7: boundary group only between instructions
    p_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.gv && s_q.code >= CODE_W'(C_TRACE)) |-> ($past(s_q.phase) == PH_IDLE));

    // R8: no lower code was eligible when the grant was decided
    p_lowest_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.gv |-> (($past(elig) & ((8'd1 << s_q.code) - 8'd1)) == 8'd0));

    // R10: after any grant the core is in exception processing
    p_grant_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.gv |-> (s_q.phase == PH_EXC));
endmodule

// File: tb/test_exc_prio_seq.sv
module test_exc_prio_seq;
    localparam int DW = 4;
    localparam int WATCHDOG = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    exc_req = '0;
    logic          insn_start = 1'b0;
    logic          insn_done = 1'b0;
    logic          exc_done = 1'b0;
    logic          handler_return = 1'b0;
    logic          grant_valid;
    logic [2:0]    grant_code;
    logic          save_ctx;
    logic [DW-1:0] ctx_depth;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    exc_prio_seq #(.DEPTH_W(DW)) i_exc_prio_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .exc_req        (exc_req),
        .insn_start     (insn_start),
        .insn_done      (insn_done),
        .exc_done       (exc_done),
        .handler_return (handler_return),
        .grant_valid    (grant_valid),
        .grant_code     (grant_code),
        .save_ctx       (save_ctx),
        .ctx_depth      (ctx_depth)
    );

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            failures = failures + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            report();
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        check(act == exp, tag, act, exp);
    endtask

    // Drive inputs for one clock, then sample after the falling edge
    task automatic cyc(input logic [7:0] rq, input bit st, input bit dn,
                       input bit ed, input bit hr);
        exc_req = rq; insn_start = st; insn_done = dn;
        exc_done = ed; handler_return = hr;
        @(negedge clk);
        exc_req = '0; insn_start = 1'b0; insn_done = 1'b0;
        exc_done = 1'b0; handler_return = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // ph: 0 between instructions, 1 executing, 2 exception processing
    function automatic int expect_code(input int mask, input int ph, input bit st);
        for (int i = 0; i < 8; i++) begin
            if (mask[i]) begin
                if (i <= 2) return i;
                if (i == 3 && ph == 1) return i;
                if (i == 4 && ph == 0 && st) return i;
                if (i >= 5 && ph == 0) return i;
            end
        end
        return -1;
    endfunction

    initial begin
        int exp;
        int base;
        @(negedge clk);
        do_reset();

        // R11: reset state
        chk_eq("R11 grant_valid after reset", grant_valid, 0);
        chk_eq("R11 depth after reset", ctx_depth, 0);

        // Sweep every request set in every phase (R2 R3 R4 R5 R6 R7 R8 R9 R10)
        for (int pc = 0; pc < 4; pc++) begin
            for (int m = 1; m < 256; m++) begin
                int ph;
                bit st;
                do_reset();
                ph = (pc == 3) ? 0 : pc;
                st = (pc == 3);
                base = 0;
                if (pc == 1) begin
                    cyc(8'h00, 1, 0, 0, 0);
                end else if (pc == 2) begin
                    cyc(8'h02, 0, 0, 0, 0);
                    chk_eq("R4 setup fault grant", grant_code, 1);
                    base = 1;
                end
                cyc(m[7:0], st, 0, 0, 0);
                exp = expect_code(m, ph, st);
                if (exp < 0) begin
                    chk_eq("R8 no eligible request no grant", grant_valid, 0);
                end else begin
                    chk_eq("R8 grant_valid", grant_valid, 1);
                    chk_eq("R8 lowest eligible code", grant_code, exp);
                    chk_eq("R3 save_ctx", save_ctx, (exp != 0) ? 1 : 0);
                    chk_eq("R9 R2 depth after grant", ctx_depth, (exp == 0) ? 0 : base + 1);
                end
                if (m[0]) begin
                    // R2: everything raised with reset is gone
                    cyc(8'h00, 0, 0, 1, 0);
                    cyc(8'h00, 0, 0, 0, 0);
                    chk_eq("R2 flushed request not granted", grant_valid, 0);
                    cyc(8'h00, 0, 0, 0, 0);
                    chk_eq("R2 still nothing pending", grant_valid, 0);
                end
            end
        end

        // R1: interrupt held through an instruction, granted at the boundary
        do_reset();
        cyc(8'h00, 1, 0, 0, 0);
        cyc(8'h80, 0, 0, 0, 0);
        chk_eq("R1 interrupt waits during execution", grant_valid, 0);
        cyc(8'h00, 0, 0, 0, 0);
        cyc(8'h00, 0, 0, 0, 0);
        chk_eq("R1 still waiting", grant_valid, 0);
        cyc(8'h00, 0, 1, 0, 0);
        chk_eq("R10 no grant in done cycle", grant_valid, 0);
        cyc(8'h00, 0, 0, 0, 0);
        chk_eq("R1 latched interrupt granted", grant_valid, 1);
        chk_eq("R1 interrupt code", grant_code, 7);

        // Trap with trace and interrupt, then bus fault during processing
        do_reset();
        cyc(8'h00, 1, 0, 0, 0);
        cyc(8'hA8, 0, 0, 0, 0);
        chk_eq("R5 trap first", grant_code, 3);
        chk_eq("R9 depth 1", ctx_depth, 1);
        cyc(8'h00, 0, 0, 1, 0);
        chk_eq("R10 exc_done cycle no grant", grant_valid, 0);
        cyc(8'h00, 0, 0, 0, 0);
        chk_eq("R7 trace second", grant_code, 5);
        chk_eq("R9 depth 2", ctx_depth, 2);
        cyc(8'h00, 0, 0, 0, 0);
        chk_eq("R7 interrupt waits for exc_done", grant_valid, 0);
        cyc(8'h00, 0, 0, 1, 0);
        cyc(8'h00, 0, 0, 0, 0);
        chk_eq("R7 interrupt third", grant_code, 7);
        chk_eq("R9 depth 3", ctx_depth, 3);
        cyc(8'h04, 0, 0, 0, 0);
        chk_eq("R4 bus fault preempts processing", grant_code, 2);
        chk_eq("R9 depth 4", ctx_depth, 4);
        cyc(8'h00, 0, 0, 0, 1);
        chk_eq("R9 return pops to 3", ctx_depth, 3);
        cyc(8'h00, 0, 0, 0, 1);
        cyc(8'h00, 0, 0, 0, 1);
        cyc(8'h00, 0, 0, 0, 1);
        chk_eq("R9 unwound to 0", ctx_depth, 0);
        cyc(8'h00, 0, 0, 0, 1);
        chk_eq("R9 holds at 0", ctx_depth, 0);

        // R9: grant and return in the same cycle
        cyc(8'h02, 0, 0, 0, 1);
        chk_eq("R9 grant with return unchanged", ctx_depth, 0);

        // R9: saturation at the top
        do_reset();
        for (int k = 0; k < 20; k++) cyc(8'h02, 0, 0, 0, 0);
        chk_eq("R9 saturates at max", ctx_depth, (1 << DW) - 1);

        // R2: reset flushes a waiting interrupt and clears depth
        do_reset();
        cyc(8'h02, 0, 0, 0, 0);
        cyc(8'h00, 0, 0, 1, 0);
        cyc(8'h00, 1, 0, 0, 0);
        cyc(8'h80, 0, 0, 0, 0);
        cyc(8'h01, 0, 0, 0, 0);
        chk_eq("R2 reset code", grant_code, 0);
        chk_eq("R2 reset no save", save_ctx, 0);
        chk_eq("R2 depth cleared", ctx_depth, 0);
        cyc(8'h00, 0, 0, 1, 0);
        for (int k = 0; k < 3; k++) begin
            cyc(8'h00, 0, 0, 0, 0);
            chk_eq("R2 interrupt flushed", grant_valid, 0);
        end

        done = 1'b1;
        report();
    end
endmodule